// File: doc/BRIEF.md
# Sticky Oldest-Fallback Warp Scheduler

This block picks one warp per cycle from a set of resident warp contexts in a compute core. Each resident warp is either ready to issue or parked while it waits for a memory reply. The selection is greedy. The warp granted in the previous cycle is granted again for as long as it stays ready. When that warp parks or drops out, the grant falls back to the ready warp that has gone longest without a grant.

The surrounding pipeline issues one instruction for the granted warp in the same cycle. If that instruction touches memory, it raises `issueIsMem`, and the warp is parked until a reply tagged with its ID comes back. A reply counts in the cycle it arrives, so a returning warp can compete in that same cycle. When no resident warp is either ready or parked, the block raises a request for a new batch of warps. Fetching that batch is left to the logic around the block.

Top module: `sticky_warp_sched`

## Requirements
- R1: After reset, no warp is parked and no previous grant is remembered. With `warpValid` all zero, `grantValid` is 0 and `batchReq` is 1.
- R2: A grant (`grantValid`=1) only ever names a warp whose `warpValid` bit is 1 and that is not parked. `grantValid` is 0 whenever no such warp exists.
- R3: If the warp granted in the previous cycle is still ready, it is granted again, whatever the ages of the other warps.
- R4: Each warp has an age. The age is cleared when the warp is granted and grows by one in each cycle the warp is ready but not granted. A warp that is not ready keeps its age. When the previous warp is not ready, the grant goes to the ready warp with the largest age.
- R5: Among ready warps of equal largest age, the lowest warp ID wins.
- R6: A granted warp whose instruction has `issueIsMem`=1 is parked at the next edge and is not granted again until a reply with `respValid`=1 and `respWarp` equal to its ID arrives.
- R7: A reply makes its warp ready in the same cycle it arrives, so that warp can be granted in that cycle.
- R8: If a reply and a new parking hit the same warp in one cycle, the reply is applied first and the warp ends up parked.
- R9: `batchReq` is 1 exactly when no warp with `warpValid`=1 is ready or parked. While warps are parked and none is ready, `batchReq` and `grantValid` are both 0.
- R10: A cycle with no grant forgets the previous grant, so the next pick is by age and ID. A warp whose `warpValid` is 0 loses its parked state and its age.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| warpValid | input | NUM_WARPS | Resident warp mask |
| respValid | input | 1 | Memory reply present this cycle |
| respWarp | input | log2(NUM_WARPS) | Warp ID the reply belongs to |
| issueIsMem | input | 1 | The instruction of the current grant is a load or store |
| grantValid | output | 1 | A warp is granted this cycle |
| grantWarp | output | log2(NUM_WARPS) | Granted warp ID |
| batchReq | output | 1 | No warp is ready or parked; a new batch is wanted |

## Verification
The first pattern is a long run with no memory instructions. It shows that the grant stays on one warp even while the other warps age, which is what separates this policy from round robin. The second pattern parks warps one at a time with their ages set up so that the oldest ready warp is not the lowest ID. This separates a true oldest search from a lowest-ID priority, and a separate step with equal ages checks the tie rule. The third pattern places replies in the same cycle as a pick, or in the same cycle as a new parking, which checks the order in which a reply and a suspension take effect. The last pattern drops the resident mask to zero and restores it, which checks that the remembered grant is forgotten and that the batch request rises and falls.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  // strobes from the control to the datapath for the current cycle
  typedef struct packed {
    logic grant;    // a warp is granted this cycle
    logic suspend;  // the granted warp parks at the coming edge
  } wsStrobe_t;
endpackage

// File: rtl/wsched_data.sv
module wsched_data
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 16,
  parameter int AGE_W     = 8,
  localparam int IW       = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_WARPS-1:0]            warpValid,
  input  logic                            respValid,
  input  logic [IW-1:0]                   respWarp,
  input  wsStrobe_t                       strb,
  input  logic [IW-1:0]                   grantId,
  output logic [NUM_WARPS-1:0]            readyNow,
  output logic [NUM_WARPS-1:0][AGE_W-1:0] ages,
  output logic                            lastValid,
  output logic [IW-1:0]                   lastId,
  output logic                            batchReq
);
  logic [NUM_WARPS-1:0] suspQ, suspD, respOh, grantOh, stillParked;
  logic [NUM_WARPS-1:0][AGE_W-1:0] ageQ;

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_warp
    assign respOh[g]  = respValid && (respWarp == IW'(g));
    assign grantOh[g] = strb.grant && (grantId == IW'(g));

    // the age is cleared on a grant, grows while ready and waiting,
    // and holds while parked
    always_ff @(posedge clk) begin
      if (!rst_n || !warpValid[g] || grantOh[g]) begin
        ageQ[g] <= '0;
      end else if (readyNow[g] && ageQ[g] != {AGE_W{1'b1}}) begin
        ageQ[g] <= ageQ[g] + 1'b1;
      end
    end
  end

  // replies land first, then the granted warp may park
  assign stillParked = suspQ & ~respOh & warpValid;
  assign readyNow    = warpValid & ~stillParked;
  assign suspD       = (stillParked | (strb.suspend ? grantOh : '0)) & warpValid;
  assign ages        = ageQ;
  assign batchReq    = ~|readyNow && ~|stillParked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      suspQ     <= '0;
      lastValid <= 1'b0;
      lastId    <= '0;
    end else begin
      suspQ     <= suspD;
      lastValid <= strb.grant;
      lastId    <= grantId;
    end
  end

  // R9
  batch_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    batchReq |-> !strb.grant);
endmodule

// File: rtl/wsched_ctrl.sv
module wsched_ctrl
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 16,
  parameter int AGE_W     = 8,
  localparam int IW       = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_WARPS-1:0]            readyNow,
  input  logic [NUM_WARPS-1:0][AGE_W-1:0] ages,
  input  logic                            lastValid,
  input  logic [IW-1:0]                   lastId,
  input  logic                            issueIsMem,
  output wsStrobe_t                       strb,
  output logic [IW-1:0]                   grantId
);
  logic             anyReady, keepLast;
  logic [IW-1:0]    oldId;
  logic [AGE_W-1:0] oldAge;

  // linear oldest search; a strict compare keeps the lowest ID on ties
  always_comb begin
    anyReady = 1'b0;
    oldId    = '0;
    oldAge   = '0;
    for (int i = 0; i < NUM_WARPS; i++) begin
      if (readyNow[i] && (!anyReady || ages[i] > oldAge)) begin
        anyReady = 1'b1;
        oldId    = IW'(i);
        oldAge   = ages[i];
      end
    end
  end

  assign keepLast     = lastValid && readyNow[lastId];
  assign grantId      = keepLast ? lastId : oldId;
  assign strb.grant   = anyReady;
  assign strb.suspend = anyReady && issueIsMem;

  // R2
  grant_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.grant |-> readyNow[grantId]);
endmodule

// File: rtl/sticky_warp_sched.sv
module sticky_warp_sched
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 16,
  parameter int AGE_W     = 8,
  localparam int IW       = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] warpValid,
  input  logic                 respValid,
  input  logic [IW-1:0]        respWarp,
  input  logic                 issueIsMem,
  output logic                 grantValid,
  output logic [IW-1:0]        grantWarp,
  output logic                 batchReq
);
  wsStrobe_t                       strb;
  logic [IW-1:0]                   grantId, lastId;
  logic [NUM_WARPS-1:0]            readyNow;
  logic [NUM_WARPS-1:0][AGE_W-1:0] ages;
  logic                            lastValid;

  wsched_data #(.NUM_WARPS(NUM_WARPS), .AGE_W(AGE_W)) u_data (
    .clk(clk), .rst_n(rst_n), .warpValid(warpValid),
    .respValid(respValid), .respWarp(respWarp),
    .strb(strb), .grantId(grantId), .readyNow(readyNow), .ages(ages),
    .lastValid(lastValid), .lastId(lastId), .batchReq(batchReq)
  );

  wsched_ctrl #(.NUM_WARPS(NUM_WARPS), .AGE_W(AGE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .readyNow(readyNow), .ages(ages),
    .lastValid(lastValid), .lastId(lastId), .issueIsMem(issueIsMem),
    .strb(strb), .grantId(grantId)
  );

  assign grantValid = strb.grant;
  assign grantWarp  = grantId;

  // R3
  sticky_regrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grantValid && !issueIsMem) |=>
      (!warpValid[$past(grantWarp)] || (grantValid && grantWarp == $past(grantWarp))));

  // R6
  parked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grantValid && issueIsMem) |=>
      (!grantValid || grantWarp != $past(grantWarp)
       || (respValid && respWarp == $past(grantWarp))));
endmodule

// File: tb/test_sticky_warp_sched.sv
module test_sticky_warp_sched;
  localparam int NW = 16;
  localparam int IW = $clog2(NW);

  typedef struct {
    logic          gv;
    logic [IW-1:0] gw;
    logic          req;
    string         tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NW-1:0] warpValid = '0;
  logic respValid = 1'b0;
  logic [IW-1:0] respWarp = '0;
  logic issueIsMem = 1'b0;
  logic grantValid, batchReq;
  logic [IW-1:0] grantWarp;

  expItem_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sticky_warp_sched #(.NUM_WARPS(NW)) i_sticky_warp_sched (
    .clk(clk), .rst_n(rst_n), .warpValid(warpValid),
    .respValid(respValid), .respWarp(respWarp), .issueIsMem(issueIsMem),
    .grantValid(grantValid), .grantWarp(grantWarp), .batchReq(batchReq)
  );

  // driver: apply one cycle of inputs and queue what the outputs must be
  task automatic step(input logic [NW-1:0] v, input logic rv, input int rw,
                      input logic mem, input logic gv, input int gw,
                      input logic req, input string tag);
    expItem_t e;
    @(negedge clk);
    warpValid  = v;
    respValid  = rv;
    respWarp   = IW'(rw);
    issueIsMem = mem;
    e.gv = gv; e.gw = IW'(gw); e.req = req; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: compare mid-cycle, well before the next rising edge
  initial begin
    forever begin
      expItem_t e;
      @(negedge clk);
      #5;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        nChecks++;
        if (grantValid !== e.gv || batchReq !== e.req ||
            (e.gv && grantWarp !== e.gw)) begin
          nFails++;
          $display("FAIL %s: got gv=%0b gw=%0d req=%0b, expected gv=%0b gw=%0d req=%0b",
                   e.tag, grantValid, grantWarp, batchReq, e.gv, e.gw, e.req);
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: got timeout, expected end of run");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  localparam logic [NW-1:0] W4 = 16'h000F;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    //    valid  rv rw mem  gv gw req tag
    step('0,     0, 0, 0,   0, 0, 1, "R1 reset idle");
    step(W4,     0, 0, 0,   1, 0, 0, "R5 tie lowest id");
    step(W4,     0, 0, 0,   1, 0, 0, "R3 sticky");
    step(W4,     0, 0, 1,   1, 0, 0, "R3 sticky with mem");
    step(W4,     0, 0, 0,   1, 1, 0, "R6 parked skipped, R5 tie");
    step(W4,     0, 0, 1,   1, 1, 0, "R3 sticky park w1");
    step(W4,     0, 0, 0,   1, 2, 0, "R4 fallback w2");
    step(W4,     0, 0, 1,   1, 2, 0, "R3 sticky park w2");
    step(W4,     1, 0, 0,   1, 3, 0, "R4 oldest beats lower id");
    step(W4,     0, 0, 1,   1, 3, 0, "R3 sticky park w3");
    step(W4,     1, 1, 0,   1, 0, 0, "R4 oldest vs returning w1");
    step(W4,     0, 0, 1,   1, 0, 0, "R3 sticky park w0");
    step(W4,     0, 0, 1,   1, 1, 0, "R6 only w1 ready");
    step(W4,     0, 0, 0,   0, 0, 0, "R9 all parked no request");
    step(W4,     1, 2, 0,   1, 2, 0, "R7 same cycle reply");
    step(W4,     1, 2, 1,   1, 2, 0, "R8 reply then park");
    step(W4,     0, 0, 0,   0, 0, 0, "R8 w2 stays parked");
    step('0,     0, 0, 0,   0, 0, 1, "R9 empty pools request");
    step(16'h8,  0, 0, 0,   1, 3, 0, "R2 only resident w3");
    step('0,     0, 0, 0,   0, 0, 1, "R10 idle cycle");
    step(16'h9,  0, 0, 0,   1, 0, 0, "R10 last forgotten");
    step(16'h9,  0, 0, 0,   1, 0, 0, "R3 sticky after refill");
    @(negedge clk);
    warpValid = '0;
    #15;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule